// File: doc/BRIEF.md
# EEPROM Burst Register Loader

After reset this block reads an initialization image from a serial EEPROM, one byte per request, and turns its register section into 32-bit writes on a register-bus master port. A gate byte at a fixed offset decides whether the section is used at all. The byte after the gate holds the number of bursts. Each burst then gives a word index, a word count and the data bytes for those words. The words are written to consecutive register addresses.

The byte transport to the EEPROM, whether SPI or I2C, sits outside this block. Here it is reduced to a request/valid handshake. When the loader stops, either because the image has ended or because the gate byte was wrong, it drops its busy flag. It can also pulse an interrupt line.

Top module: `eeburst_loader`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy` is 1, `irq` is 0 and `wr_valid` is 0. The first EEPROM read requested is at byte offset 12.
- R2: If the byte at offset 12 is not 0xA5, the loader makes no register writes and reads no further bytes. It then goes idle with `busy` at 0.
- R3: If the gate byte is 0xA5, the byte at offset 13 is the number of bursts. A value of 0 ends the load with no writes.
- R4: Each burst is laid out in this order: a one-byte word index, a one-byte word count, then count × 4 data bytes. The first write of a burst goes to byte address index × 4.
- R5: Each data word is built little-endian from four consecutive bytes. The first byte lands in bits 7:0 and the fourth in bits 31:24.
- R6: Within a burst, each following write goes to the previous byte address plus 4. The address wraps modulo 2^REG_AW, so index 255 with two words writes 0x3FC and then 0x000.
- R7: A word count of 0 produces no writes for that burst. The byte that follows it is taken as the next burst's index, or the load ends if that was the last burst.
- R8: Once `wr_valid` is raised, it stays high with `wr_addr` and `wr_data` unchanged until a cycle in which `wr_ack` is 1.
- R9: `rom_req` stays high with `rom_addr` unchanged until `rom_valid` is 1. Completed reads cover consecutive offsets starting at 12, and the last one is the last byte of the image that is used.
- R10: `busy` stays 1 until the load terminates. It then goes to 0 and stays at 0 until the next reset.
- R11: When the load terminates and `irq_en` is 1, `irq` is high for exactly one cycle, in the first cycle in which `busy` is 0. When `irq_en` is 0, `irq` stays 0.
- R12: `rom_req` and `wr_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | Enables the completion pulse |
| rom_req | output | 1 | EEPROM byte read request |
| rom_addr | output | ROM_AW | EEPROM byte offset to read |
| rom_valid | input | 1 | Read data valid; completes the request |
| rom_data | input | 8 | Byte returned by the EEPROM |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | REG_AW | Register byte address |
| wr_data | output | 32 | Register write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Loader still running |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after these corner cases:
- **Wrong gate byte.** A loader that checked it badly would write registers from a blank image, or would keep reading past offset 12.
- **Zero burst count and zero word count.** A design that handled zero as 256, or that skipped the wrong number of bytes, would issue spurious writes and would get the alignment of every later burst wrong.
- **Address wrap at index 255 and byte order.** A design that got the wrap wrong would write outside the register space. One that got the byte order wrong would return byte-swapped data.
- **Random acknowledge and valid delays.** These would expose a request that changes before it is accepted, a read that overlaps a write, or a completion pulse that repeats or ignores its enable.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
    localparam logic [7:0] EBL_GATE_VALUE  = 8'hA5;
    localparam int         EBL_GATE_OFFSET = 12;

    typedef enum logic [2:0] {
        ST_GATE,
        ST_NBURST,
        ST_INDEX,
        ST_COUNT,
        ST_DATA,
        ST_WRITE,
        ST_IDLE
    } ebl_state_e;
endpackage

// File: rtl/ebl_fetch.sv
module ebl_fetch #(
    parameter int ROM_AW = 11,
    parameter int START  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    input  logic              rom_valid,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              got
);
    typedef struct packed {
        logic [ROM_AW-1:0] ptr;
    } fetch_s;

    fetch_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (want && rom_valid) begin
            s_d.ptr = s_q.ptr + ROM_AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr <= ROM_AW'(START);
        end else begin
            s_q <= s_d;
        end
    end

    assign rom_req  = want;
    assign rom_addr = s_q.ptr;
    assign got      = want && rom_valid;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && !rom_valid |=> rom_req && $stable(rom_addr));
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        got |=> rom_addr == $past(rom_addr) + ROM_AW'(1));
endmodule

// File: rtl/ebl_pack.sv
module ebl_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [7:0]  byte_in,
    output logic [31:0] word,
    output logic        last
);
    typedef struct packed {
        logic [31:0] word;
        logic [1:0]  lane;
    } pack_s;

    pack_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.word = {byte_in, s_q.word[31:8]};
            s_d.lane = s_q.lane + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word = s_q.word;
    assign last = load && (s_q.lane == 2'd3);

    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> word[31:24] == $past(byte_in));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(word));
endmodule

// File: rtl/eeburst_loader.sv
module eeburst_loader
    import ebl_pkg::*;
#(
    parameter int         ROM_AW     = 11,
    parameter int         REG_AW     = 10,
    parameter int         GATE_OFS   = EBL_GATE_OFFSET,
    parameter logic [7:0] GATE_VALUE = EBL_GATE_VALUE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    output logic              rom_req,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic              rom_valid,
    input  logic [7:0]        rom_data,
    output logic              wr_valid,
    output logic [REG_AW-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              irq
);
    localparam int WIDX_W = REG_AW - 2;

    typedef struct packed {
        ebl_state_e        state;
        logic [7:0]        bursts;
        logic [7:0]        words;
        logic [WIDX_W-1:0] widx;
        logic              irq;
    } ctl_s;

    ctl_s s_d, s_q;

    logic        want;
    logic        got;
    logic        pack_load;
    logic        pack_last;
    logic [31:0] pack_word;

    ebl_fetch #(.ROM_AW(ROM_AW), .START(GATE_OFS)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .rom_valid(rom_valid),
        .rom_req  (rom_req),
        .rom_addr (rom_addr),
        .got      (got)
    );

    ebl_pack u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pack_load),
        .byte_in(rom_data),
        .word   (pack_word),
        .last   (pack_last)
    );

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        want      = 1'b0;
        pack_load = 1'b0;
        case (s_q.state)
            ST_GATE: begin
                want = 1'b1;
                if (got) begin
                    s_d.state = (rom_data == GATE_VALUE) ? ST_NBURST : ST_IDLE;
                end
            end
            ST_NBURST: begin
                want = 1'b1;
                if (got) begin
                    s_d.bursts = rom_data;
                    s_d.state  = (rom_data == 8'd0) ? ST_IDLE : ST_INDEX;
                end
            end
            ST_INDEX: begin
                want = 1'b1;
                if (got) begin
                    s_d.widx  = WIDX_W'(rom_data);
                    s_d.state = ST_COUNT;
                end
            end
            ST_COUNT: begin
                want = 1'b1;
                if (got) begin
                    if (rom_data != 8'd0) begin
                        s_d.words = rom_data;
                        s_d.state = ST_DATA;
                    end else if (s_q.bursts == 8'd1) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.bursts = s_q.bursts - 8'd1;
                        s_d.state  = ST_INDEX;
                    end
                end
            end
            ST_DATA: begin
                want      = 1'b1;
                pack_load = got;
                if (got && pack_last) begin
                    s_d.state = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    s_d.widx = s_q.widx + WIDX_W'(1);
                    if (s_q.words != 8'd1) begin
                        s_d.words = s_q.words - 8'd1;
                        s_d.state = ST_DATA;
                    end else if (s_q.bursts == 8'd1) begin
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.bursts = s_q.bursts - 8'd1;
                        s_d.state  = ST_INDEX;
                    end
                end
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
        if (s_d.state == ST_IDLE && s_q.state != ST_IDLE) begin
            s_d.irq = irq_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state  <= ST_GATE;
            s_q.bursts <= '0;
            s_q.words  <= '0;
            s_q.widx   <= '0;
            s_q.irq    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_valid = (s_q.state == ST_WRITE);
    assign wr_addr  = {s_q.widx, 2'b00};
    assign wr_data  = pack_word;
    assign busy     = (s_q.state != ST_IDLE);
    assign irq      = s_q.irq;

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    p_no_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rom_req));
    p_busy_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
    p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy && $past(irq_en) && $past(busy));
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rom_req && !wr_valid);
endmodule

// File: tb/eeburst_loader_tb.sv
module eeburst_loader_tb;
    localparam int ROM_AW = 11;
    localparam int REG_AW = 10;
    localparam int LIMIT  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_en = 1'b0;
    logic              rom_req;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_valid = 1'b0;
    logic [7:0]        rom_data = 8'h00;
    logic              wr_valid;
    logic [REG_AW-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              wr_ack = 1'b0;
    logic              busy;
    logic              irq;

    int total = 0;
    int bad   = 0;

    logic [7:0]        img [0:255];
    logic [REG_AW-1:0] exp_a [$];
    logic [31:0]       exp_d [$];
    int                exp_last;
    logic [REG_AW-1:0] got_a [$];
    logic [31:0]       got_d [$];

    always #4 clk = ~clk;

    eeburst_loader #(.ROM_AW(ROM_AW), .REG_AW(REG_AW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_en   (irq_en),
        .rom_req  (rom_req),
        .rom_addr (rom_addr),
        .rom_valid(rom_valid),
        .rom_data (rom_data),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ack   (wr_ack),
        .busy     (busy),
        .irq      (irq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic build_expect();
        int p;
        int nb;
        int idx;
        int cnt;
        exp_a.delete();
        exp_d.delete();
        if (img[12] != 8'hA5) begin
            exp_last = 12;
            return;
        end
        p  = 13;
        nb = int'(img[13]);
        for (int b = 0; b < nb; b++) begin
            idx = int'(img[p+1]);
            cnt = int'(img[p+2]);
            p   = p + 2;
            for (int w = 0; w < cnt; w++) begin
                exp_a.push_back(REG_AW'((idx + w) * 4));
                exp_d.push_back({img[p+4], img[p+3], img[p+2], img[p+1]});
                p = p + 4;
            end
        end
        exp_last = p;
    endtask

    task automatic fill_random();
        for (int i = 0; i < 256; i++) img[i] = 8'($urandom);
    endtask

    task automatic run_case(input string name, input logic ien);
        int  cyc = 0;
        int  post = 0;
        int  nirq = 0;
        int  nrd = 0;
        int  lastrd = -1;
        int  hold_err = 0;
        int  ovl_err = 0;
        int  seq_err = 0;
        int  sticky_err = 0;
        int  irq_busy_err = 0;
        bit  low_seen = 0;
        bit  pend = 0;
        logic [REG_AW-1:0] pa = '0;
        logic [31:0]       pd = '0;
        build_expect();
        got_a.delete();
        got_d.delete();
        irq_en = ien;
        @(negedge clk);
        rst_n = 1'b0;
        rom_valid = 1'b0;
        wr_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1 && irq === 1'b0 && wr_valid === 1'b0, "R1",
            {name, " reset outputs"}, {busy, irq, wr_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rom_req === 1'b1 && rom_addr == ROM_AW'(12) && busy === 1'b1, "R1",
            {name, " first read offset"}, rom_addr, 12);
        while (cyc < LIMIT) begin
            if (pend && !(wr_valid && wr_addr == pa && wr_data == pd)) hold_err++;
            if (wr_valid && rom_req) ovl_err++;
            if (irq) nirq++;
            if (irq && busy) irq_busy_err++;
            if (busy && low_seen) sticky_err++;
            if (!busy) low_seen = 1;
            rom_valid = rom_req && ($urandom % 3 != 0);
            rom_data  = img[rom_addr[7:0]];
            if (rom_valid) begin
                if (int'(rom_addr) != 12 + nrd) seq_err++;
                nrd++;
                lastrd = int'(rom_addr);
            end
            wr_ack = wr_valid && ($urandom % 3 != 0);
            if (wr_valid && wr_ack) begin
                got_a.push_back(wr_addr);
                got_d.push_back(wr_data);
                pend = 0;
            end else begin
                pend = wr_valid;
            end
            pa = wr_addr;
            pd = wr_data;
            if (low_seen) post++;
            if (post > 6) break;
            @(negedge clk);
            cyc++;
        end
        rom_valid = 1'b0;
        wr_ack = 1'b0;
        chk(cyc < LIMIT, "R10", {name, " load terminated"}, cyc, LIMIT);
        chk(sticky_err == 0, "R10", {name, " busy stays low"}, sticky_err, 0);
        chk(got_a.size() == exp_a.size(), "R4", {name, " write count"},
            got_a.size(), exp_a.size());
        for (int i = 0; i < got_a.size() && i < exp_a.size(); i++) begin
            chk(got_a[i] == exp_a[i], "R6", {name, " write address"}, got_a[i], exp_a[i]);
            chk(got_d[i] == exp_d[i], "R5", {name, " write data"}, got_d[i], exp_d[i]);
        end
        chk(hold_err == 0, "R8", {name, " write held until ack"}, hold_err, 0);
        chk(ovl_err == 0, "R12", {name, " read/write overlap"}, ovl_err, 0);
        chk(seq_err == 0, "R9", {name, " consecutive reads"}, seq_err, 0);
        chk(lastrd == exp_last, "R9", {name, " last byte read"}, lastrd, exp_last);
        chk(nirq == (ien ? 1 : 0) && irq_busy_err == 0, "R11", {name, " irq pulses"},
            nirq, ien ? 1 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R2: gate byte wrong
        fill_random();
        img[12] = 8'h00;
        run_case("gate00", 1'b1);
        chk(got_a.size() == 0, "R2", "gate00 no writes", got_a.size(), 0);
        fill_random();
        img[12] = 8'hA4;
        run_case("gateA4", 1'b0);

        // R3: zero bursts
        fill_random();
        img[12] = 8'hA5;
        img[13] = 8'h00;
        run_case("nb0", 1'b1);
        chk(got_a.size() == 0, "R3", "nb0 no writes", got_a.size(), 0);

        // R5 R6 R7: directed bursts with zero count and wrap
        fill_random();
        img[12] = 8'hA5; img[13] = 8'd3;
        img[14] = 8'h10; img[15] = 8'd2;
        img[16] = 8'h01; img[17] = 8'h02; img[18] = 8'h03; img[19] = 8'h04;
        img[24] = 8'h20; img[25] = 8'd0;
        img[26] = 8'hFF; img[27] = 8'd2;
        run_case("directed", 1'b1);
        chk(got_d.size() > 0 && got_d[0] == 32'h04030201, "R5", "little-endian word",
            got_d.size() > 0 ? got_d[0] : 0, 32'h04030201);
        chk(got_a.size() == 4 && got_a[2] == 10'h3FC && got_a[3] == 10'h000, "R6",
            "wrap at index 255", got_a.size() == 4 ? got_a[3] : 0, 0);
        chk(got_a.size() > 2 && got_a[0] == 10'h040 && got_a[2] == 10'h3FC, "R7",
            "zero-count burst skipped", got_a.size() > 2 ? got_a[2] : 0, 10'h3FC);

        // random images
        for (int t = 0; t < 8; t++) begin
            int p;
            int nb;
            fill_random();
            nb = 1 + int'($urandom % 5);
            img[12] = 8'hA5;
            img[13] = 8'(nb);
            p = 13;
            for (int b = 0; b < nb; b++) begin
                int cnt;
                cnt = int'($urandom % 7);
                img[p+2] = 8'(cnt);
                p = p + 2 + cnt * 4;
            end
            run_case($sformatf("rand%0d", t), 1'($urandom % 2));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule